// File: doc/BRIEF.md
# USB Hub Downstream Port Engine

This block runs one downstream port of a full-/low-speed USB hub. It reads the port's single-ended receive pair, finds out when a device arrives or leaves and which speed it runs at, and moves the port through its life cycle: unpowered, waiting for a device, attached but disabled, under bus reset, active, and suspended. The hub core gives it commands on a small command port, clears its status-change flags by writing ones, and supplies a slow timing tick from which all debounce and reset intervals are counted.

The engine switches the port's power itself and watches an over-current input. A trip cuts power and latches an indicator. While the port is suspended, a resume signalled by the attached device is passed upward as a one-cycle wake event. Several instances, one per port, can be placed side by side. Each instance classifies its own device's speed, so a hub can mix speeds freely across its ports.

Top module: `hub_dport`

## Requirements
- R1: The pair {dp_in, dm_in} decodes as 00 = SE0, 01 = logic 0, 10 = logic 1, 11 = undefined. The undefined state never counts as idle, so it can never connect a device.
- R2: While powered with no device attached, a logic 1 held unchanged for DEB_TICKS ticks connects a full-speed device (st_lowspd = 0). A logic 0 held the same way connects a low-speed device (st_lowspd = 1). Either case sets st_conn and change bit 0 (connect change). The port then sits disabled.
- R3: An idle level that changes before DEB_TICKS ticks have passed does not connect the port.
- R4: An SE0 held for DEB_TICKS ticks while the port is disabled, enabled or suspended returns it to the no-device state and sets change bit 0.
- R5: Command code 3 (reset), given while a device is attached, drives drv_se0 for rst_len ticks. The port then becomes enabled and sets change bit 1 (reset change).
- R6: Command code 4 enables a disabled port. Code 5 disables an enabled or suspended port. Code 6 suspends an enabled port. Code 7 resumes a suspended port to enabled and sets change bit 3 (suspend change).
- R7: Command code 1 powers an unpowered port (pwr_en = 1, no device). Command code 2 removes power from any state. An unpowered port ignores its line.
- R8: ovc_in high on a powered port clears pwr_en, forces the unpowered state, sets st_ovc and sets change bit 2. st_ovc stays set until a power-on is accepted, and a power-on is refused while ovc_in is high.
- R9: In the suspended state, the K level (logic 0 for a full-speed device, logic 1 for a low-speed device) on the line gives a one-cycle wake_evt pulse, enables the port and sets change bit 3.
- R10: Writing one to a chg_clr bit clears that change bit. A change bit set in the same cycle as its clear stays set.
- R11: After reset, pwr_en, drv_se0, wake_evt, all status outputs and all change bits are 0.
- R12: A command that does not apply to the current state (for example suspend while disabled) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timing tick for debounce and reset intervals |
| dp_in | input | 1 | Received single-ended D+ |
| dm_in | input | 1 | Received single-ended D- |
| ovc_in | input | 1 | Over-current sense, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 power on, 2 power off, 3 reset, 4 enable, 5 disable, 6 suspend, 7 resume |
| rst_len | input | RLEN_W | Bus-reset length in ticks |
| chg_clr | input | 4 | Write-one-to-clear for the change bits |
| pwr_en | output | 1 | Port power switch enable |
| drv_se0 | output | 1 | Drive SE0 on the port (bus reset) |
| wake_evt | output | 1 | Remote-wakeup pulse to the hub core |
| st_conn | output | 1 | Device attached |
| st_en | output | 1 | Port enabled and active |
| st_susp | output | 1 | Port suspended |
| st_lowspd | output | 1 | Attached device is low speed |
| st_ovc | output | 1 | Latched over-current indicator |
| chg | output | 4 | Change bits: 0 connect, 1 reset, 2 over-current, 3 suspend |

## Verification
The hub core can clear a change bit in the very cycle in which the state machine sets it. This collision is the case most likely to lose an event. The bench provokes it by issuing a resume command together with a write-one to the suspend-change bit in one clock, then expects the bit to read back as set. The same collision appears during a remote wakeup and at the end of a reset, where the register-level assertion checks that a set always wins.

// File: rtl/hub_dport_pkg.sv
package hub_dport_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_D0  = 2'b01,
    LN_D1  = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_DISC = 3'd1,
    PS_DIS  = 3'd2,
    PS_RST  = 3'd3,
    PS_EN   = 3'd4,
    PS_SUSP = 3'd5
  } pstate_t;

  localparam logic [2:0] CMD_PWR_ON  = 3'd1;
  localparam logic [2:0] CMD_PWR_OFF = 3'd2;
  localparam logic [2:0] CMD_RESET   = 3'd3;
  localparam logic [2:0] CMD_ENABLE  = 3'd4;
  localparam logic [2:0] CMD_DISABLE = 3'd5;
  localparam logic [2:0] CMD_SUSPEND = 3'd6;
  localparam logic [2:0] CMD_RESUME  = 3'd7;

  localparam int NCHG     = 4;
  localparam int CHG_CONN = 0;
  localparam int CHG_RST  = 1;
  localparam int CHG_OVC  = 2;
  localparam int CHG_SUSP = 3;

  function automatic line_t line_decode(input logic dp, input logic dm);
    return line_t'({dp, dm});
  endfunction

  function automatic logic line_is_idle(input line_t l);
    return (l == LN_D0) || (l == LN_D1);
  endfunction

  // K is the opposite of the idle level of the attached device
  function automatic line_t k_level(input logic lowspd);
    return lowspd ? LN_D1 : LN_D0;
  endfunction

  function automatic logic cmd_hit(input logic v, input logic [2:0] c,
                                   input logic [2:0] want);
    return v && (c == want);
  endfunction

  // true on the tick that completes a reset of len ticks
  function automatic logic reset_done(input logic [15:0] cnt, input logic [15:0] len);
    return (cnt + 16'd1) >= len;
  endfunction

endpackage

// File: rtl/hub_dport_line.sv
module hub_dport_line
  import hub_dport_pkg::*;
#(
  parameter int DEB_TICKS = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  dp,
  input  logic  dm,
  output line_t line_q,
  output logic  stable
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  line_t         raw;
  logic [CW-1:0] cnt;

  assign raw    = line_decode(dp, dm);
  assign stable = (cnt == CW'(DEB_TICKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= LN_SE0;
      cnt    <= '0;
    end else begin
      line_q <= raw;
      if (raw != line_q)                        cnt <= '0;
      else if (tick && cnt != CW'(DEB_TICKS))   cnt <= cnt + 1'b1;
    end
  end

  AST_DEB_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEB_TICKS)); // R3
  AST_DEB_RESTART: assert property (@(posedge clk) disable iff (rst)
    (line_q != $past(line_q)) |-> !stable); // R3

endmodule

// File: rtl/hub_dport_chg.sv
module hub_dport_chg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_i) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i))); // R10
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0)); // R10

endmodule

// File: rtl/hub_dport.sv
module hub_dport
  import hub_dport_pkg::*;
#(
  parameter int DEB_TICKS = 8,
  parameter int RLEN_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dp_in,
  input  logic              dm_in,
  input  logic              ovc_in,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [RLEN_W-1:0] rst_len,
  input  logic [3:0]        chg_clr,
  output logic              pwr_en,
  output logic              drv_se0,
  output logic              wake_evt,
  output logic              st_conn,
  output logic              st_en,
  output logic              st_susp,
  output logic              st_lowspd,
  output logic              st_ovc,
  output logic [3:0]        chg
);
  pstate_t           state, nxt;
  line_t             line_q;
  logic              stable;
  logic              lowspd_q, ovc_q, wake_q;
  logic [RLEN_W-1:0] rcnt;
  logic [NCHG-1:0]   chg_set;

  // named events
  logic ovc_hit, off_req, pwr_on_ok, conn_ok, disc_hit, wake_hit, rst_done, wake_fire;

  hub_dport_line #(.DEB_TICKS(DEB_TICKS)) u_line (
    .clk(clk), .rst(rst), .tick(tick), .dp(dp_in), .dm(dm_in),
    .line_q(line_q), .stable(stable)
  );

  hub_dport_chg #(.N(NCHG)) u_chg (
    .clk(clk), .rst(rst), .set_i(chg_set), .clr_i(chg_clr), .q(chg)
  );

  assign ovc_hit   = ovc_in && (state != PS_OFF);
  assign off_req   = cmd_hit(cmd_valid, cmd_code, CMD_PWR_OFF) && (state != PS_OFF);
  assign pwr_on_ok = cmd_hit(cmd_valid, cmd_code, CMD_PWR_ON) && (state == PS_OFF) && !ovc_in;
  assign conn_ok   = (state == PS_DISC) && stable && line_is_idle(line_q);
  assign disc_hit  = stable && (line_q == LN_SE0) &&
                     ((state == PS_DIS) || (state == PS_EN) || (state == PS_SUSP));
  assign wake_hit  = (state == PS_SUSP) && (line_q == k_level(lowspd_q));
  assign rst_done  = (state == PS_RST) && tick &&
                     reset_done(16'(rcnt), 16'(rst_len));

  always_comb begin
    nxt       = state;
    chg_set   = '0;
    wake_fire = 1'b0;
    if (ovc_hit) begin
      nxt              = PS_OFF;
      chg_set[CHG_OVC] = 1'b1;
    end else if (off_req) begin
      nxt = PS_OFF;
    end else if (disc_hit) begin
      nxt               = PS_DISC;
      chg_set[CHG_CONN] = 1'b1;
    end else begin
      case (state)
        PS_OFF:  if (pwr_on_ok) nxt = PS_DISC;
        PS_DISC: if (conn_ok) begin
                   nxt               = PS_DIS;
                   chg_set[CHG_CONN] = 1'b1;
                 end
        PS_DIS: begin
          if (cmd_hit(cmd_valid, cmd_code, CMD_RESET))       nxt = PS_RST;
          else if (cmd_hit(cmd_valid, cmd_code, CMD_ENABLE)) nxt = PS_EN;
        end
        PS_RST:  if (rst_done) begin
                   nxt              = PS_EN;
                   chg_set[CHG_RST] = 1'b1;
                 end
        PS_EN: begin
          if (cmd_hit(cmd_valid, cmd_code, CMD_RESET))        nxt = PS_RST;
          else if (cmd_hit(cmd_valid, cmd_code, CMD_DISABLE)) nxt = PS_DIS;
          else if (cmd_hit(cmd_valid, cmd_code, CMD_SUSPEND)) nxt = PS_SUSP;
        end
        PS_SUSP: begin
          if (wake_hit) begin
            nxt               = PS_EN;
            chg_set[CHG_SUSP] = 1'b1;
            wake_fire         = 1'b1;
          end else if (cmd_hit(cmd_valid, cmd_code, CMD_RESUME)) begin
            nxt               = PS_EN;
            chg_set[CHG_SUSP] = 1'b1;
          end else if (cmd_hit(cmd_valid, cmd_code, CMD_DISABLE)) nxt = PS_DIS;
          else if (cmd_hit(cmd_valid, cmd_code, CMD_RESET))       nxt = PS_RST;
        end
        default: nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_OFF;
      lowspd_q <= 1'b0;
      ovc_q    <= 1'b0;
      wake_q   <= 1'b0;
      rcnt     <= '0;
    end else begin
      state  <= nxt;
      wake_q <= wake_fire;
      if (conn_ok)        lowspd_q <= (line_q == LN_D0);
      if (ovc_hit)        ovc_q <= 1'b1;
      else if (pwr_on_ok) ovc_q <= 1'b0;
      if (state != PS_RST) rcnt <= '0;
      else if (tick)       rcnt <= rcnt + 1'b1;
    end
  end

  assign pwr_en    = (state != PS_OFF);
  assign drv_se0   = (state == PS_RST);
  assign wake_evt  = wake_q;
  assign st_conn   = (state == PS_DIS) || (state == PS_RST) ||
                     (state == PS_EN)  || (state == PS_SUSP);
  assign st_en     = (state == PS_EN);
  assign st_susp   = (state == PS_SUSP);
  assign st_lowspd = lowspd_q && st_conn;
  assign st_ovc    = ovc_q;

  AST_SE0_POWERED: assert property (@(posedge clk) disable iff (rst)
    drv_se0 |-> (pwr_en && st_conn)); // R5
  AST_RESET_END: assert property (@(posedge clk) disable iff (rst)
    (st_en && $past(drv_se0)) |-> chg[CHG_RST]); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> (!st_conn && !drv_se0 && !st_en)); // R7
  AST_OVC_TRIP: assert property (@(posedge clk) disable iff (rst)
    (ovc_in && pwr_en) |=> (!pwr_en && st_ovc && chg[CHG_OVC])); // R8
  AST_WAKE_FROM_SUSP: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> (st_en && $past(st_susp) && chg[CHG_SUSP])); // R9
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> !wake_evt); // R9

endmodule

// File: tb/tb_hub_dport.sv
module tb_hub_dport;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       dp_in = 1'b0, dm_in = 1'b0, ovc_in = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] rst_len = 8'd5;
  logic [3:0] chg_clr = 4'd0;
  logic       pwr_en, drv_se0, wake_evt, st_conn, st_en, st_susp, st_lowspd, st_ovc;
  logic [3:0] chg;

  hub_dport #(.DEB_TICKS(8), .RLEN_W(8)) dut (
    .clk(clk), .rst(rst), .tick(tick), .dp_in(dp_in), .dm_in(dm_in),
    .ovc_in(ovc_in), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rst_len(rst_len), .chg_clr(chg_clr), .pwr_en(pwr_en), .drv_se0(drv_se0),
    .wake_evt(wake_evt), .st_conn(st_conn), .st_en(st_en), .st_susp(st_susp),
    .st_lowspd(st_lowspd), .st_ovc(st_ovc), .chg(chg)
  );

  always #5 clk = ~clk;

  // tick every 4 clocks, driven away from the active edge
  int tphase = 0;
  always @(negedge clk) begin
    tphase = (tphase + 1) % 4;
    tick   = (tphase == 0);
  end

  int wake_cnt = 0, se0_cycles = 0;
  always @(negedge clk) begin
    if (wake_evt) wake_cnt = wake_cnt + 1;
    if (drv_se0)  se0_cycles = se0_cycles + 1;
  end

  localparam logic [11:0] B_PWR = 12'h800, B_SE0 = 12'h400, B_CONN = 12'h200,
    B_EN = 12'h100, B_SUSP = 12'h080, B_LS = 12'h040, B_OVC = 12'h020,
    B_WAKE = 12'h010, C_CONN = 12'h001, C_RST = 12'h002, C_OVC = 12'h004,
    C_SUSP = 12'h008, ALL = 12'hFFF;

  int n_run = 0, n_fail = 0, wake_base = 0;
  logic [11:0] stv;
  assign stv = {pwr_en, drv_se0, st_conn, st_en, st_susp, st_lowspd, st_ovc,
                (wake_cnt != wake_base), chg};

  typedef struct {
    string       req;
    logic [11:0] mask;
    logic [11:0] exp;
  } item_t;
  item_t sb_q[$];
  event  mon_go;

  // monitor: pops expected items and compares with the live status
  initial begin
    forever begin
      @(mon_go);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if ((stv & it.mask) !== it.exp) begin
          n_fail++;
          $display("FAIL %s: status actual %03h expected %03h (mask %03h)",
                   it.req, stv & it.mask, it.exp, it.mask);
        end
      end
    end
  end

  task automatic expect_st(input string req, input logic [11:0] mask, input logic [11:0] exp);
    item_t it;
    it.req = req; it.mask = mask; it.exp = exp;
    sb_q.push_back(it);
    -> mon_go;
    #1;
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] code, input logic [3:0] clr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; chg_clr = clr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0; chg_clr = 4'd0;
  endtask

  task automatic cmd(input logic [2:0] code);
    send(code, 4'd0);
  endtask

  task automatic clr(input logic [3:0] v);
    @(negedge clk);
    chg_clr = v;
    @(negedge clk);
    chg_clr = 4'd0;
  endtask

  task automatic set_line(input logic p, input logic m);
    dp_in = p; dm_in = m;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    expect_st("R11 reset state", ALL, 12'h000);

    cmd(3'd1);
    expect_st("R7 power on", ALL, B_PWR);

    set_line(1'b1, 1'b1);
    wait_clk(160);
    expect_st("R1 undefined line never connects", ALL, B_PWR);

    set_line(1'b1, 1'b0);
    wait_clk(12);
    set_line(1'b0, 1'b0);
    wait_clk(160);
    expect_st("R3 short idle does not connect", ALL, B_PWR);

    set_line(1'b1, 1'b0);
    wait_clk(160);
    expect_st("R2 full-speed connect", ALL, B_PWR | B_CONN | C_CONN);

    cmd(3'd6);
    expect_st("R12 suspend while disabled ignored", ALL, B_PWR | B_CONN | C_CONN);

    clr(4'b0001);
    expect_st("R10 write-one clears connect change", ALL, B_PWR | B_CONN);

    se0_cycles = 0;
    cmd(3'd3);
    wait_clk(4);
    expect_st("R5 reset drives SE0", ALL, B_PWR | B_SE0 | B_CONN);
    wait_clk(30);
    expect_st("R5 reset ends enabled", ALL, B_PWR | B_CONN | B_EN | C_RST);
    chk_range("R5 SE0 length for 5 ticks", se0_cycles, 16, 21);
    clr(4'hF);

    cmd(3'd6);
    expect_st("R6 suspend", ALL, B_PWR | B_CONN | B_SUSP);
    cmd(3'd7);
    expect_st("R6 host resume", ALL, B_PWR | B_CONN | B_EN | C_SUSP);
    clr(4'hF);

    cmd(3'd6);
    set_line(1'b0, 1'b1);
    wait_clk(4);
    expect_st("R9 remote wakeup on K", ALL, B_PWR | B_CONN | B_EN | B_WAKE | C_SUSP);
    set_line(1'b1, 1'b0);
    wake_base = wake_cnt;
    clr(4'hF);

    cmd(3'd6);
    send(3'd7, 4'b1000);
    expect_st("R10 set wins over same-cycle clear", ALL, B_PWR | B_CONN | B_EN | C_SUSP);
    clr(4'hF);

    cmd(3'd5);
    expect_st("R6 disable", ALL, B_PWR | B_CONN);
    cmd(3'd4);
    expect_st("R6 enable", ALL, B_PWR | B_CONN | B_EN);

    set_line(1'b0, 1'b0);
    wait_clk(160);
    expect_st("R4 disconnect on SE0", ALL, B_PWR | C_CONN);
    clr(4'hF);

    set_line(1'b0, 1'b1);
    wait_clk(160);
    expect_st("R2 low-speed connect", ALL, B_PWR | B_CONN | B_LS | C_CONN);
    clr(4'hF);

    @(negedge clk);
    ovc_in = 1'b1;
    wait_clk(2);
    expect_st("R8 over-current trip", ALL, B_OVC | C_OVC);
    cmd(3'd1);
    expect_st("R8 power-on refused during over-current", ALL, B_OVC | C_OVC);
    @(negedge clk);
    ovc_in = 1'b0;
    cmd(3'd1);
    expect_st("R8 power-on clears indicator", B_PWR | B_OVC, B_PWR);
    wait_clk(160);
    expect_st("R2 low-speed reconnect after power-on", ALL,
              B_PWR | B_CONN | B_LS | C_OVC | C_CONN);

    cmd(3'd2);
    expect_st("R7 power off", B_PWR | B_CONN | B_EN, 12'h000);

    wait_clk(4);
    summary();
  end
endmodule